// File: doc/BRIEF.md
# FIFO Flag Threshold Register File

This block holds the two programmable thresholds a synchronous FIFO uses for its almost-empty and almost-full flags. Each threshold is split into a low part and a high part, so the four parts are loaded one 9-bit word at a time on the write clock. They can also be read back one word at a time on the read clock. The register file has no address. Two independent 2-bit step counters, one per clock, walk through the four parts in a fixed cycle. The first threshold's low part comes first, then its high part, then the second threshold's low part, then its high part, and the cycle then wraps.

The write and read enables and the shared load/second-enable pin are sampled while reset is held. If the shared pin is low during reset, the block is in load mode: that pin then selects register access instead of FIFO data. Otherwise the block stays passive and both thresholds keep their reset value of 7. The assembled thresholds are driven to the flag logic at `$clog2(DEPTH)` bits.

The interface has no back-pressure. Each qualifying clock edge consumes one input word or produces one readback word, and nothing can stall it. A write to the registers and a readback must not be issued in the same cycle.

Top module: `ofs_regfile`

## Requirements
- R1: During synchronous reset (`rst_n` low on a clock edge), both thresholds become 7, `rd_word` becomes 0, and both step counters return to the first step.
- R2: The level of `ld_n` sampled during reset selects the mode: low gives load mode (`cfg_load`=1), high gives pass-through mode (`cfg_load`=0). In pass-through mode, no write or readback ever changes `empty_ofs`, `full_ofs` or `rd_word`. The mode holds until the next reset.
- R3: In load mode, a rising `wclk` with `ld_n`=0 and `wen1_n`=0 writes one register part and advances the write step. With `wen1_n`=1, or with `ld_n`=1 (an ordinary FIFO write), nothing is written and the step does not advance.
- R4: The write steps run in this order: almost-empty low, almost-empty high, almost-full low, almost-full high. After the fourth step the order wraps to the first.
- R5: A write changes only the addressed part. The other part of the same threshold keeps its value. The new threshold is visible on `empty_ofs`/`full_ofs` right after the writing edge.
- R6: A low part takes `din[min(OFS_W,8)-1:0]` into threshold bits [min(OFS_W,8)-1:0]. A high part takes `din[OFS_W-9:0]` into threshold bits [OFS_W-1:8], and only exists when OFS_W>8. All other `din` bits are ignored.
- R7: In load mode, a rising `rclk` with `ld_n`=0, `ren1_n`=0 and `ren2_n`=0 loads the next part into `rd_word` and advances the read step. Otherwise `rd_word` holds and the read step does not advance.
- R8: Readback follows the same four-step cyclic order as writes, using its own counter. Writes do not move the read step, and reads do not move the write step.
- R9: Readback words are zero-extended. Bits that are not part of a threshold read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous reset, active low, applied on both clocks |
| ld_n | input | 1 | Register access select, active low; sampled at reset for mode |
| wen1_n | input | 1 | Write enable, active low |
| din | input | DW | Write data word |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| cfg_load | output | 1 | 1 when load mode was chosen at reset |
| rd_word | output | DW | Readback word register |
| empty_ofs | output | OFS_W | Assembled almost-empty threshold |
| full_ofs | output | OFS_W | Assembled almost-full threshold |

## Verification
A write step counter that has slipped shows up as soon as the next load lands in the wrong part of `empty_ofs` or `full_ofs`, which is visible right after that edge. A read step counter that has slipped shows up on the next readback word. A wrong mode latch, or an enable decode that lets a non-load cycle through, changes a threshold or `rd_word` on the very edge where it should have held. The bench follows each such cycle with a port check. It interleaves loads and reads so that a shared or coupled counter gives a wrong value within one access.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    STEP_AE_LO = 2'd0,
    STEP_AE_HI = 2'd1,
    STEP_AF_LO = 2'd2,
    STEP_AF_HI = 2'd3
  } ofs_step_e;

  function automatic int lo_width(input int ofs_w);
    return (ofs_w > 8) ? 8 : ofs_w;
  endfunction
endpackage

// File: rtl/ofs_step_ctr.sv
module ofs_step_ctr
  import ofs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  output ofs_step_e step
);
  always_ff @(posedge clk) begin
    if (!rst_n)   step <= STEP_AE_LO;
    else if (adv) step <= ofs_step_e'(step + 2'd1);
  end

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && step == STEP_AF_HI) |=> step == STEP_AE_LO); // R4
  AST_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(step)); // R3
endmodule

// File: rtl/ofs_wr_bank.sv
module ofs_wr_bank
  import ofs_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int DW    = 9,
  localparam int LO_W = lo_width(OFS_W),
  localparam int HI_W = OFS_W - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  ofs_step_e        step,
  input  logic [DW-1:0]    din,
  output logic [OFS_W-1:0] ae,
  output logic [OFS_W-1:0] af
);
  logic [LO_W-1:0] ae_lo, af_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ae_lo <= LO_W'(7);
      af_lo <= LO_W'(7);
    end else if (we && step == STEP_AE_LO) begin
      ae_lo <= din[LO_W-1:0];
    end else if (we && step == STEP_AF_LO) begin
      af_lo <= din[LO_W-1:0];
    end
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] ae_hi, af_hi;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ae_hi <= '0;
          af_hi <= '0;
        end else if (we && step == STEP_AE_HI) begin
          ae_hi <= din[HI_W-1:0];
        end else if (we && step == STEP_AF_HI) begin
          af_hi <= din[HI_W-1:0];
        end
      end
      assign ae = {ae_hi, ae_lo};
      assign af = {af_hi, af_lo};
    end else begin : g_lo_only
      assign ae = ae_lo;
      assign af = af_lo;
    end
  endgenerate

  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (we && step == STEP_AE_LO) |=> ae[OFS_W-1:LO_W] == $past(ae[OFS_W-1:LO_W]) || HI_W == 0); // R5
  AST_AE_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && step == STEP_AE_LO) |=> ae[LO_W-1:0] == $past(din[LO_W-1:0])); // R6
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import ofs_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int DW    = 9,
  localparam int LO_W = lo_width(OFS_W),
  localparam int HI_W = OFS_W - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             re,
  input  ofs_step_e        step,
  input  logic [OFS_W-1:0] ae,
  input  logic [OFS_W-1:0] af,
  output logic [DW-1:0]    rd_word
);
  logic [DW-1:0] ae_hi_w, af_hi_w, nxt;

  generate
    if (HI_W > 0) begin : g_hi
      assign ae_hi_w = DW'(ae[OFS_W-1:LO_W]);
      assign af_hi_w = DW'(af[OFS_W-1:LO_W]);
    end else begin : g_no_hi
      assign ae_hi_w = '0;
      assign af_hi_w = '0;
    end
  endgenerate

  always_comb begin
    unique case (step)
      STEP_AE_LO: nxt = DW'(ae[LO_W-1:0]);
      STEP_AE_HI: nxt = ae_hi_w;
      STEP_AF_LO: nxt = DW'(af[LO_W-1:0]);
      default:    nxt = af_hi_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rd_word <= '0;
    else if (re) rd_word <= nxt;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rd_word)); // R7
  AST_RD_AE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (re && step == STEP_AE_LO) |=> rd_word == DW'($past(ae[LO_W-1:0]))); // R9
endmodule

// File: rtl/ofs_regfile.sv
module ofs_regfile
  import ofs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 9,
  localparam int OFS_W = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             ld_n,
  input  logic             wen1_n,
  input  logic [DW-1:0]    din,
  input  logic             ren1_n,
  input  logic             ren2_n,
  output logic             cfg_load,
  output logic [DW-1:0]    rd_word,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);
  logic      wmode, rmode, wr_load, rd_fire;
  ofs_step_e wstep, rstep;

  always_ff @(posedge wclk) if (!rst_n) wmode <= !ld_n;
  always_ff @(posedge rclk) if (!rst_n) rmode <= !ld_n;

  assign cfg_load = wmode;
  assign wr_load  = wmode && !ld_n && !wen1_n;
  assign rd_fire  = rmode && !ld_n && !ren1_n && !ren2_n;

  ofs_step_ctr u_wstep (.clk(wclk), .rst_n(rst_n), .adv(wr_load), .step(wstep));
  ofs_step_ctr u_rstep (.clk(rclk), .rst_n(rst_n), .adv(rd_fire), .step(rstep));

  ofs_wr_bank #(.OFS_W(OFS_W), .DW(DW)) u_bank (
    .clk(wclk), .rst_n(rst_n), .we(wr_load), .step(wstep), .din(din),
    .ae(empty_ofs), .af(full_ofs)
  );

  ofs_rd_port #(.OFS_W(OFS_W), .DW(DW)) u_rd (
    .clk(rclk), .rst_n(rst_n), .re(rd_fire), .step(rstep),
    .ae(empty_ofs), .af(full_ofs), .rd_word(rd_word)
  );

  AST_MODE_HOLD: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> $stable(cfg_load)); // R2
  AST_NO_LOAD_STABLE: assert property (@(posedge wclk) disable iff (!rst_n)
    !(cfg_load && !ld_n && !wen1_n) |=> $stable(empty_ofs) && $stable(full_ofs)); // R3
endmodule

// File: tb/ofs_regfile_test.sv
`timescale 1ns/1ps
module ofs_regfile_test;
  typedef struct packed {
    logic       ld_n, wen1_n, ren1_n, ren2_n;
    logic [8:0] din;
    logic [9:0] ae, af;
    logic [8:0] rd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,1'b1, 9'h1A5, 10'h0A5, 10'h007, 9'h000}, // R6 ae low, bit 8 dropped
    '{1'b0,1'b1,1'b1,1'b1, 9'h1FF, 10'h0A5, 10'h007, 9'h000}, // R3 wen1 high
    '{1'b1,1'b0,1'b1,1'b1, 9'h0FF, 10'h0A5, 10'h007, 9'h000}, // R3 fifo write
    '{1'b0,1'b0,1'b1,1'b1, 9'h1FE, 10'h2A5, 10'h007, 9'h000}, // R5 ae high
    '{1'b0,1'b0,1'b1,1'b1, 9'h13C, 10'h2A5, 10'h03C, 9'h000}, // R4 af low
    '{1'b0,1'b0,1'b1,1'b1, 9'h003, 10'h2A5, 10'h33C, 9'h000}, // R4 af high
    '{1'b0,1'b0,1'b1,1'b1, 9'h011, 10'h211, 10'h33C, 9'h000}, // R4 wrap
    '{1'b0,1'b1,1'b0,1'b0, 9'h000, 10'h211, 10'h33C, 9'h011}, // R7 read ae low
    '{1'b0,1'b1,1'b1,1'b0, 9'h000, 10'h211, 10'h33C, 9'h011}, // R7 ren1 high
    '{1'b0,1'b1,1'b0,1'b1, 9'h000, 10'h211, 10'h33C, 9'h011}, // R7 ren2 high
    '{1'b0,1'b1,1'b0,1'b0, 9'h000, 10'h211, 10'h33C, 9'h002}, // R9 ae high
    '{1'b1,1'b1,1'b0,1'b0, 9'h000, 10'h211, 10'h33C, 9'h002}, // R7 fifo read
    '{1'b0,1'b1,1'b0,1'b0, 9'h000, 10'h211, 10'h33C, 9'h03C}, // R8 af low
    '{1'b0,1'b1,1'b0,1'b0, 9'h000, 10'h211, 10'h33C, 9'h003}, // R8 af high
    '{1'b0,1'b1,1'b0,1'b0, 9'h000, 10'h211, 10'h33C, 9'h011}  // R8 wrap
  };

  logic clk = 1'b0;
  logic rst_n, ld_n, wen1_n, ren1_n, ren2_n;
  logic [8:0] din, rd_word;
  logic [9:0] empty_ofs, full_ofs;
  logic cfg_load;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  ofs_regfile uut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .ld_n(ld_n), .wen1_n(wen1_n),
    .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .cfg_load(cfg_load),
    .rd_word(rd_word), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic l, input logic w, input logic r1, input logic r2, input logic [8:0] d);
    ld_n = l; wen1_n = w; ren1_n = r1; ren2_n = r2; din = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset(input logic mode_ld_n);
    rst_n = 1'b0;
    repeat (3) step(mode_ld_n, 1'b1, 1'b1, 1'b1, 9'h0);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b1, 9'h0);
  endtask

  initial begin
    rst_n = 1'b0; ld_n = 1'b1; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1; din = '0;
    @(negedge clk);
    do_reset(1'b0);
    check("R1 ae reset", 32'(empty_ofs), 32'h7);
    check("R1 af reset", 32'(full_ofs), 32'h7);
    check("R1 rd reset", 32'(rd_word), 32'h0);
    check("R2 load mode", 32'(cfg_load), 32'h1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ld_n, VEC[i].wen1_n, VEC[i].ren1_n, VEC[i].ren2_n, VEC[i].din);
      check($sformatf("R3-vec%0d ae", i), 32'(empty_ofs), 32'(VEC[i].ae));
      check($sformatf("R5-vec%0d af", i), 32'(full_ofs), 32'(VEC[i].af));
      check($sformatf("R7-vec%0d rd", i), 32'(rd_word), 32'(VEC[i].rd));
    end

    // R8: write step untouched by the reads above; sits at ae high
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'h0E3);
    check("R8 write step independent", 32'(empty_ofs), 32'h311);
    // R8: read step untouched by writes; sits at ae high
    step(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
    check("R8 read step independent", 32'(rd_word), 32'h003);

    // R1: reset returns both counters to the first step and restores defaults
    do_reset(1'b0);
    check("R1 ae default again", 32'(empty_ofs), 32'h7);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'h055);
    check("R1 write step restarts", 32'(empty_ofs), 32'h055);
    step(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
    check("R1 read step restarts", 32'(rd_word), 32'h055);

    // R2: pass-through mode ignores load and readback cycles
    do_reset(1'b1);
    check("R2 passthrough mode", 32'(cfg_load), 32'h0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'h1FF);
    check("R2 no load ae", 32'(empty_ofs), 32'h7);
    check("R2 no load af", 32'(full_ofs), 32'h7);
    step(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
    check("R2 no readback", 32'(rd_word), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule